// File: doc/BRIEF.md
# Interlaced Raster Timing Generator

This block walks a video raster: a dot counter steps once per clock across a line, a line counter steps once per line across a frame, and a field flag alternates between even and odd frames when interlaced output is selected. From the current position it decodes a packed sync-status word that a host can read at any time. It also raises a single-cycle frame strobe when the raster reaches the end of vertical retrace.

Frame geometry, sync widths and the front porch come from four small registers loaded through a plain write port. The registers can be rewritten while the raster runs. A write never restarts the counters. New limits apply from the next cycle's comparison. The back porch is a build-time parameter counted in dot clocks.

Top module: `raster_timing_gen`

## Requirements
- R1: After reset the dot counter, the line counter and the field flag are zero, and the frame strobe is low. The geometry register resets to 0x0270035F, giving 864 dots and 625 lines. The sync-timing register resets to a vsync count of 5 and a hsync field of 0x3F. Interlace is off. The front-porch field resets to 0.
- R2: The dot counter counts from 0 up to the dot limit, where the dot limit is geometry bits [9:0]. On the cycle after it reaches or exceeds that limit, it returns to 0 and the line advances.
- R3: The line limit is geometry bits [25:16]. When a line ends with the line counter at or above the line limit, the line counter returns to 0. At that frame wrap the field flag inverts if interlace is on (sync-config bit 4) and holds otherwise. The field flag never changes at any other time.
- R4: The write port takes wr_sel as follows:
  - 0 selects geometry. Only the bits under mask 0x03FF03FF are kept.
  - 1 selects sync-config. Only bit 4, interlace, is kept.
  - 2 selects sync timing. Vsync lines come from bits [11:8] and the hsync field from bits [6:0].
  - 3 selects the front porch, bits [9:0].
  - A written value governs from the next clock edge.
  - A write never resets the counters.
  - A counter already beyond a reduced limit wraps at its next step.
- R5: Status bits [9:0] show the current line. Bit 10 shows the field flag, with 1 meaning odd.
- R6: On a line whose bit 0 equals the field flag:
  - Bit 12 is set when the dot position exceeds 2*(hsync field+1).
  - When the line is at or above the vsync count, bit 13 is set.
  - When the line is at or above the vsync count, bit 11 is also set if the dot position exceeds front-porch field+1.
- R7: On a line of the other parity:
  - At or above the vsync count, bits 12 and 13 are set.
  - At or above the vsync count, bit 11 is also set while the dot position is below (dot limit+1) minus BACK_PORCH_DOTS.
  - Below the vsync count, only bit 12 of bits 11 to 13 is set.
- R8: The frame strobe is high for one cycle, namely the first cycle of line 42. It fires when the line counter steps from below 42 to 42 or above, or wraps to a value of 42 or above. It never fires in frames with fewer lines.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select (0 geometry, 1 sync-config, 2 sync timing, 3 front porch) |
| wr_data | input | 32 | Write data |
| sync_status | output | 14 | Packed line, field, active, hsync-off and vsync-off word |
| frame_strobe | output | 1 | One-cycle pulse at end of retrace |

## Verification
A wrong dot or line count shows at once in status bits [9:0] or in the sync bits of the same cycle. It also moves the frame strobe away from the first dot of line 42. A field flag that is wrong appears at the next frame wrap as a flipped bit 10. That same error swaps the parity-dependent decoding of bits 11 to 13 on every line. A register mask or select fault shows within one line, because the shrunk geometry changes where the counters wrap.

// File: rtl/rtg_pkg.sv
package rtg_pkg;

  localparam int DOT_W  = 10;
  localparam int LINE_W = 10;
  localparam int STAT_W = 14;

  typedef struct packed {
    logic [LINE_W-1:0] line_last;
    logic [DOT_W-1:0]  dot_last;
    logic              interlace;
    logic [3:0]        vs_lines;
    logic [6:0]        hs_field;
    logic [9:0]        fp_field;
  } rtg_cfg_t;

  // hsync width in dots: two dots per unit, field plus one
  function automatic logic [10:0] f_hsync_dots(input logic [6:0] hs);
    return ({4'd0, hs} + 11'd1) << 1;
  endfunction

  // front porch in dots
  function automatic logic [10:0] f_porch_dots(input logic [9:0] fp);
    return {1'b0, fp} + 11'd1;
  endfunction

  // first dot past the active region on off-parity lines, floored at zero
  function automatic logic [10:0] f_active_end(input logic [DOT_W-1:0] dot_last,
                                               input int unsigned bp);
    logic [11:0] len;
    len = {2'd0, dot_last} + 12'd1;
    if (int'(len) <= int'(bp)) return 11'd0;
    return 11'(int'(len) - int'(bp));
  endfunction

  function automatic logic [STAT_W-1:0] f_status(
      input logic [LINE_W-1:0] line, input logic [DOT_W-1:0] dot,
      input logic field, input logic [3:0] vs, input logic [10:0] hsw,
      input logic [10:0] fpd, input logic [10:0] act_end);
    logic [STAT_W-1:0] s;
    logic in_vid;
    s = '0;
    s[9:0] = line;
    s[10]  = field;
    in_vid = line >= {6'd0, vs};
    if (line[0] == field) begin
      s[12] = {1'b0, dot} > hsw;
      if (in_vid) begin
        s[13] = 1'b1;
        s[11] = {1'b0, dot} > fpd;
      end
    end else begin
      s[12] = 1'b1;
      if (in_vid) begin
        s[13] = 1'b1;
        s[11] = {1'b0, dot} < act_end;
      end
    end
    return s;
  endfunction

endpackage

// File: rtl/rtg_regs.sv
module rtg_regs
  import rtg_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [1:0]  wr_sel,
  input  logic [31:0] wr_data,
  output rtg_cfg_t    cfg
);
  localparam logic [31:0] GEOM_RST = 32'h0270_035F;
  localparam logic [31:0] GEOM_MSK = 32'h03FF_03FF;

  logic [31:0] geom_q;
  logic        il_q;
  logic [3:0]  vs_q;
  logic [6:0]  hs_q;
  logic [9:0]  fp_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      geom_q <= GEOM_RST;
      il_q   <= 1'b0;
      vs_q   <= 4'd5;
      hs_q   <= 7'h3F;
      fp_q   <= '0;
    end else if (wr_en) begin
      case (wr_sel)
        2'd0: geom_q <= wr_data & GEOM_MSK;
        2'd1: il_q   <= wr_data[4];
        2'd2: begin vs_q <= wr_data[11:8]; hs_q <= wr_data[6:0]; end
        default: fp_q <= wr_data[9:0];
      endcase
    end
  end

  assign cfg.line_last = geom_q[25:16];
  assign cfg.dot_last  = geom_q[9:0];
  assign cfg.interlace = il_q;
  assign cfg.vs_lines  = vs_q;
  assign cfg.hs_field  = hs_q;
  assign cfg.fp_field  = fp_q;

  a_r4_geom_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (geom_q & ~GEOM_MSK) == 32'd0);
  a_r4_geom_load: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == 2'd0) |=> geom_q == ($past(wr_data) & GEOM_MSK));
endmodule

// File: rtl/rtg_raster_cnt.sv
module rtg_raster_cnt
  import rtg_pkg::*;
#(
  parameter int RETRACE_END = 42
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DOT_W-1:0]  dot_last,
  input  logic [LINE_W-1:0] line_last,
  input  logic              interlace,
  output logic [DOT_W-1:0]  dot_cnt,
  output logic [LINE_W-1:0] line_cnt,
  output logic              field_odd,
  output logic              frame_strobe,
  output logic              dot_wrap,
  output logic              frame_wrap
);
  localparam logic [LINE_W-1:0] RE = LINE_W'(RETRACE_END);

  logic [LINE_W-1:0] line_nxt;
  logic              strobe_nxt;

  assign dot_wrap   = dot_cnt >= dot_last;
  assign frame_wrap = dot_wrap && (line_cnt >= line_last);

  always_comb begin
    if (frame_wrap)    line_nxt = '0;
    else if (dot_wrap) line_nxt = line_cnt + 1'b1;
    else               line_nxt = line_cnt;
    strobe_nxt = dot_wrap && (line_nxt >= RE) &&
                 ((line_cnt < RE) || (line_nxt < line_cnt));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dot_cnt      <= '0;
      line_cnt     <= '0;
      field_odd    <= 1'b0;
      frame_strobe <= 1'b0;
    end else begin
      dot_cnt      <= dot_wrap ? '0 : dot_cnt + 1'b1;
      line_cnt     <= line_nxt;
      frame_strobe <= strobe_nxt;
      if (frame_wrap && interlace) field_odd <= ~field_odd;
    end
  end

  a_r2_dot_restart: assert property (@(posedge clk) disable iff (!rst_n)
    dot_wrap |=> dot_cnt == '0);
  a_r2_line_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !dot_wrap |=> line_cnt == $past(line_cnt));
  a_r3_frame_restart: assert property (@(posedge clk) disable iff (!rst_n)
    frame_wrap |=> line_cnt == '0);
  a_r3_field_toggle: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_wrap && interlace) |=> field_odd != $past(field_odd));
  a_r3_field_steady: assert property (@(posedge clk) disable iff (!rst_n)
    !(frame_wrap && interlace) |=> $stable(field_odd));
  a_r8_strobe_place: assert property (@(posedge clk) disable iff (!rst_n)
    frame_strobe |-> (line_cnt == RE && dot_cnt == '0));
  a_r8_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
    frame_strobe |=> !frame_strobe);
endmodule

// File: rtl/rtg_status.sv
module rtg_status
  import rtg_pkg::*;
#(
  parameter int BACK_PORCH_DOTS = 108
) (
  input  logic              clk,
  input  logic              rst_n,
  input  rtg_cfg_t          cfg,
  input  logic [DOT_W-1:0]  dot_cnt,
  input  logic [LINE_W-1:0] line_cnt,
  input  logic              field_odd,
  output logic [STAT_W-1:0] status
);
  logic [10:0] hsw, fpd, act_end;

  assign hsw     = f_hsync_dots(cfg.hs_field);
  assign fpd     = f_porch_dots(cfg.fp_field);
  assign act_end = f_active_end(cfg.dot_last, BACK_PORCH_DOTS);
  assign status  = f_status(line_cnt, dot_cnt, field_odd, cfg.vs_lines,
                            hsw, fpd, act_end);

  a_r6_active_in_vid: assert property (@(posedge clk) disable iff (!rst_n)
    status[11] |-> status[13]);
  a_r7_offline_hsync: assert property (@(posedge clk) disable iff (!rst_n)
    (line_cnt[0] != field_odd) |-> status[12]);
  a_r5_line_field: assert property (@(posedge clk) disable iff (!rst_n)
    (status[9:0] == line_cnt) && (status[10] == field_odd));
endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen
  import rtg_pkg::*;
#(
  parameter int RETRACE_END     = 42,
  parameter int BACK_PORCH_DOTS = 108
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [1:0]  wr_sel,
  input  logic [31:0] wr_data,
  output logic [13:0] sync_status,
  output logic        frame_strobe
);
  rtg_cfg_t          cfg;
  logic [DOT_W-1:0]  dot_cnt;
  logic [LINE_W-1:0] line_cnt;
  logic              field_odd;
  logic              dot_wrap;
  logic              frame_wrap;

  rtg_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .cfg(cfg)
  );

  rtg_raster_cnt #(.RETRACE_END(RETRACE_END)) u_cnt (
    .clk(clk), .rst_n(rst_n), .dot_last(cfg.dot_last),
    .line_last(cfg.line_last), .interlace(cfg.interlace),
    .dot_cnt(dot_cnt), .line_cnt(line_cnt), .field_odd(field_odd),
    .frame_strobe(frame_strobe), .dot_wrap(dot_wrap), .frame_wrap(frame_wrap)
  );

  rtg_status #(.BACK_PORCH_DOTS(BACK_PORCH_DOTS)) u_stat (
    .clk(clk), .rst_n(rst_n), .cfg(cfg), .dot_cnt(dot_cnt),
    .line_cnt(line_cnt), .field_odd(field_odd), .status(sync_status)
  );

  a_r1_reset_state: assert property (@(posedge clk)
    !rst_n |=> (sync_status[10:0] == 11'd0 && !frame_strobe));
  a_r3_wrap_needs_dot: assert property (@(posedge clk) disable iff (!rst_n)
    frame_wrap |-> dot_wrap);
endmodule

// File: tb/raster_timing_gen_tb.sv
module raster_timing_gen_tb;
  localparam int BP = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = 2'd0;
  logic [31:0] wr_data = 32'd0;
  logic [13:0] sync_status;
  logic        frame_strobe;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // model state
  int m_dot = 0, m_line = 0, m_fld = 0, m_stb = 0;
  int m_dl = 863, m_ll = 624, m_il = 0, m_vs = 5, m_hs = 63, m_fp = 0;
  int stb_seen = 0;

  always #4 clk = ~clk;

  raster_timing_gen #(.RETRACE_END(42), .BACK_PORCH_DOTS(BP)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .sync_status(sync_status), .frame_strobe(frame_strobe)
  );

  function automatic logic [13:0] exp_status();
    logic [13:0] s;
    int hsw, fpd, aend;
    s = 14'(m_line);
    s[10] = m_fld[0];
    hsw  = 2 * (m_hs + 1);
    fpd  = m_fp + 1;
    aend = (m_dl + 1) - BP;
    if ((m_line % 2) == m_fld) begin
      if (m_dot > hsw) s[12] = 1'b1;
      if (m_line >= m_vs) begin
        s[13] = 1'b1;
        if (m_dot > fpd) s[11] = 1'b1;
      end
    end else if (m_line >= m_vs) begin
      s[13:12] = 2'b11;
      if (m_dot < aend) s[11] = 1'b1;
    end else begin
      s[12] = 1'b1;
    end
    return s;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h (line %0d dot %0d)", req, act, exp, m_line, m_dot);
    end
  endtask

  task automatic compare();
    logic [13:0] e;
    e = exp_status();
    chk("R2/R5 line", int'(sync_status[9:0]), int'(e[9:0]));
    chk("R3/R5 field", int'(sync_status[10]), int'(e[10]));
    if ((m_line % 2) == m_fld) chk("R6 sync bits", int'(sync_status[13:11]), int'(e[13:11]));
    else                       chk("R7 sync bits", int'(sync_status[13:11]), int'(e[13:11]));
    chk("R8 strobe", int'(frame_strobe), m_stb);
    if (frame_strobe) stb_seen++;
  endtask

  task automatic advance();
    int old;
    if (m_dot >= m_dl) begin
      m_dot = 0;
      old = m_line;
      if (m_line >= m_ll) begin
        m_line = 0;
        if (m_il != 0) m_fld = 1 - m_fld;
      end else m_line++;
      m_stb = (m_line >= 42 && (old < 42 || m_line < old)) ? 1 : 0;
    end else begin
      m_dot++;
      m_stb = 0;
    end
  endtask

  // one clock: drive at negedge, model the edge, compare at next negedge
  task automatic step(input bit we, input logic [1:0] sel, input logic [31:0] d);
    wr_en = we; wr_sel = sel; wr_data = d;
    @(posedge clk);
    advance();
    if (we) begin
      case (sel)
        2'd0: begin m_ll = int'(d[25:16]); m_dl = int'(d[9:0]); end
        2'd1: m_il = int'(d[4]);
        2'd2: begin m_vs = int'(d[11:8]); m_hs = int'(d[6:0]); end
        default: m_fp = int'(d[9:0]);
      endcase
    end
    @(negedge clk);
    wr_en = 1'b0;
    compare();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 2'd0, 32'd0);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state with default geometry, vsync 5, hsync 0x3F
    chk("R1 reset status", int'(sync_status), 0);
    chk("R1 reset strobe", int'(frame_strobe), 0);
    idle(200);
    // R1: default line length 864 dots reaches line 1 only after 864 cycles
    idle(700);
    chk("R1 default dot limit", int'(sync_status[9:0]), 1);

    // R4: program small geometry mid-line (counter beyond new dot limit)
    step(1'b1, 2'd2, 32'h0000_0301);
    step(1'b1, 2'd3, 32'h0000_0005);
    step(1'b1, 2'd0, 32'h0031_0017);   // 50 lines, 24 dots
    stb_seen = 0;
    idle(3 * 1200 + 50);
    chk("R8 strobe per frame", stb_seen, 3);

    // R3: interlace on
    step(1'b1, 2'd1, 32'h0000_0010);
    idle(2 * 1200 + 30);
    // R4: masked geometry write, unused sync-config bits ignored
    step(1'b1, 2'd1, 32'hFFFF_FFEF);
    step(1'b1, 2'd0, 32'hFC0F_FC0F);   // keeps 16 lines, 16 dots
    stb_seen = 0;
    idle(2 * 256 + 20);
    chk("R8 no strobe short frame", stb_seen, 0);
    chk("R4 masked geometry line bound", (int'(sync_status[9:0]) < 16) ? 1 : 0, 1);
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 150000 && !done; c++) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: run did not finish");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule